// File: doc/BRIEF.md
# Memory Access Attribute Resolver

Each memory reference, whether the processor core or the debug requester issues it, goes through this block. The block returns the reference's effective attributes: whether the reference may be cached, whether operand writes are handled precisely or imprecisely, and whether the target is write-protected. Two programmable address regions are checked in fixed priority. Region 0 is tried first, then region 1. A reference that hits neither region takes the default attribute set held in the control register.

Each region has a base for the top byte of the address, a don't-care mask over that byte, an enable bit and an attribute triple. Software programs the regions and the default set through a single-cycle register-write port. The answer appears one cycle after the request, together with a valid flag and a 2-bit code naming the source that supplied it. A write that lands in a write-protected area is flagged. The write itself is not blocked here.

Top module: `mar_attr_resolver`

## Requirements
- R1: After reset both regions are disabled and the default set is all zero, so every request resolves to noncacheable, imprecise, unprotected attributes with source code 00.
- R2: A request whose address bits [31:24] equal region 0's base in every bit where region 0's mask is 0, with region 0 enabled, takes region 0's attributes and source code 01.
- R3: A request that misses region 0 but matches enabled region 1 under region 1's mask takes region 1's attributes and source code 10.
- R4: When both regions match, region 0's attributes and source code 01 are returned.
- R5: A request that matches no region takes the default attributes and source code 00. Source code 11 never appears.
- R6: A region whose enable bit is 0 never matches, whatever its base and mask.
- R7: `rsp_wviol` is 1 exactly when the request was a write and the resolved write-protect attribute is 1. A read never raises it.
- R8: `rsp_valid` is 1 in the cycle after a cycle with `req_valid` high, and 0 otherwise. The attributes, source, violation and requester echo are registered in the same cycle.
- R9: Debug requests (`req_dbg`=1) resolve exactly as core requests do, and `rsp_dbg` echoes the requester.
- R10: A write with `cfg_we`=1 takes effect from the next cycle. `cfg_sel` picks the target: 0 is region 0, 1 is region 1, 2 is the default set, and 3 is ignored. The `cfg_wdata` fields are base [7:0], mask [15:8], enable [16], cacheable [17], precise [18] and write-protect [19]. For the default set only bits [19:17] are used. A request in the same cycle as a write sees the old setting, and address bits [23:0] never affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Target: 0 region 0, 1 region 1, 2 default, 3 none |
| cfg_wdata | input | 32 | Configuration data |
| req_valid | input | 1 | Request present |
| req_addr | input | 32 | Reference address |
| req_write | input | 1 | Reference is a write |
| req_dbg | input | 1 | Reference comes from the debug requester |
| rsp_valid | output | 1 | Response present |
| rsp_cacheable | output | 1 | Resolved cacheable attribute |
| rsp_precise | output | 1 | Resolved precise-write attribute |
| rsp_wprot | output | 1 | Resolved write-protect attribute |
| rsp_wviol | output | 1 | Write to a protected area |
| rsp_src | output | 2 | Source: 00 default, 01 region 0, 10 region 1 |
| rsp_dbg | output | 1 | Requester echo |

## Verification
The hardest situation to reach from the ports is one address that both regions claim at once while their attribute triples differ. Only a differing triple shows whether priority was honoured. The stimulus nests region 1's wider mask around region 0's narrower one, gives the two regions distinct triples, and sweeps all 256 top-byte values, so overlap, single-region hits and misses all occur in one pass. A separate case issues a request in the same cycle as a region rewrite, to expose the ordering between the write and the lookup.

// File: rtl/mar_pkg.sv
// Shared types for the attribute resolver.
// Assumes attribute fields sit contiguously in configuration words.
package mar_pkg;
    typedef struct packed {
        logic wprot;
        logic precise;
        logic cacheable;
    } attr_t;

    typedef enum logic [1:0] {
        SRC_DEF = 2'b00,
        SRC_R0  = 2'b01,
        SRC_R1  = 2'b10
    } src_e;

    localparam logic [1:0] SEL_R0  = 2'd0;
    localparam logic [1:0] SEL_R1  = 2'd1;
    localparam logic [1:0] SEL_DEF = 2'd2;
endpackage

// File: rtl/mar_cfg_regs.sv
// Holds the region descriptors and the default attribute set.
// Assumes one write per cycle; a write is visible from the next cycle.
module mar_cfg_regs
    import mar_pkg::*;
#(
    parameter int CMP_W  = 8,
    parameter int DATA_W = 32,
    parameter int NREG   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [CMP_W-1:0]  reg_base [NREG],
    output logic [CMP_W-1:0]  reg_mask [NREG],
    output logic              reg_en   [NREG],
    output attr_t             reg_attr [NREG],
    output attr_t             def_attr
);
    localparam int MASK_LO = CMP_W;
    localparam int EN_BIT  = 2 * CMP_W;
    localparam int ATTR_LO = EN_BIT + 1;
    localparam int ATTR_W  = $bits(attr_t);

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_reg
            // Load one region descriptor when selected.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    reg_base[g] <= '0;
                    reg_mask[g] <= '0;
                    reg_en[g]   <= 1'b0;
                    reg_attr[g] <= '0;
                end else if (cfg_we && cfg_sel == 2'(g)) begin
                    reg_base[g] <= cfg_wdata[CMP_W-1:0];
                    reg_mask[g] <= cfg_wdata[MASK_LO +: CMP_W];
                    reg_en[g]   <= cfg_wdata[EN_BIT];
                    reg_attr[g] <= attr_t'(cfg_wdata[ATTR_LO +: ATTR_W]);
                end
            end
        end
    endgenerate

    // Load the default attribute set when selected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            def_attr <= '0;
        end else if (cfg_we && cfg_sel == SEL_DEF) begin
            def_attr <= attr_t'(cfg_wdata[ATTR_LO +: ATTR_W]);
        end
    end

    // R6: a region that has just been disabled reports itself disabled.
    p_disable_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel == SEL_R0 && !cfg_wdata[EN_BIT]) |=> !reg_en[0]);
endmodule

// File: rtl/mar_region_match.sv
// Compares the top address bits with one region's base under its mask.
// Assumes a set mask bit means "don't care"; a disabled region never hits.
module mar_region_match #(
    parameter int ADDR_W = 32,
    parameter int CMP_W  = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [CMP_W-1:0]  base,
    input  logic [CMP_W-1:0]  mask,
    input  logic              en,
    output logic              hit
);
    logic [CMP_W-1:0] diff;

    // Flag differing bits that the mask does not excuse.
    always_comb begin
        diff = (addr[ADDR_W-1 -: CMP_W] ^ base) & ~mask;
        hit  = en && (diff == '0);
    end
endmodule

// File: rtl/mar_prio_select.sv
// Picks the lowest-numbered hitting region, else the default set.
// Assumes NREG + 1 source codes fit in two bits.
module mar_prio_select
    import mar_pkg::*;
#(
    parameter int NREG = 2
) (
    input  logic [NREG-1:0] hit,
    input  attr_t           reg_attr [NREG],
    input  attr_t           def_attr,
    output attr_t           attr,
    output logic [1:0]      src,
    output logic [NREG-1:0] grant
);
    // Walk from lowest priority to highest so the highest wins.
    always_comb begin
        attr  = def_attr;
        src   = SRC_DEF;
        grant = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (hit[i]) begin
                attr     = reg_attr[i];
                src      = 2'(i + 1);
                grant    = '0;
                grant[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/mar_attr_resolver.sv
// Resolves the effective attributes of each memory reference.
// Assumes requests are single-cycle and the answer is taken one cycle later.
module mar_attr_resolver
    import mar_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CMP_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_dbg,
    output logic              rsp_valid,
    output logic              rsp_cacheable,
    output logic              rsp_precise,
    output logic              rsp_wprot,
    output logic              rsp_wviol,
    output logic [1:0]        rsp_src,
    output logic              rsp_dbg
);
    localparam int NREG = 2;

    logic [CMP_W-1:0] reg_base [NREG];
    logic [CMP_W-1:0] reg_mask [NREG];
    logic             reg_en   [NREG];
    attr_t            reg_attr [NREG];
    attr_t            def_attr;
    logic [NREG-1:0]  hit;
    logic [NREG-1:0]  grant;
    attr_t            sel_attr;
    logic [1:0]       sel_src;

    mar_cfg_regs #(.CMP_W(CMP_W), .DATA_W(DATA_W), .NREG(NREG)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .reg_base  (reg_base),
        .reg_mask  (reg_mask),
        .reg_en    (reg_en),
        .reg_attr  (reg_attr),
        .def_attr  (def_attr)
    );

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_match
            mar_region_match #(.ADDR_W(ADDR_W), .CMP_W(CMP_W)) u_match (
                .addr (req_addr),
                .base (reg_base[g]),
                .mask (reg_mask[g]),
                .en   (reg_en[g]),
                .hit  (hit[g])
            );
        end
    endgenerate

    mar_prio_select #(.NREG(NREG)) u_prio (
        .hit      (hit),
        .reg_attr (reg_attr),
        .def_attr (def_attr),
        .attr     (sel_attr),
        .src      (sel_src),
        .grant    (grant)
    );

    // Register the valid flag every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) rsp_valid <= 1'b0;
        else        rsp_valid <= req_valid;
    end

    // Capture the resolved answer for a presented request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_cacheable <= 1'b0;
            rsp_precise   <= 1'b0;
            rsp_wprot     <= 1'b0;
            rsp_wviol     <= 1'b0;
            rsp_src       <= SRC_DEF;
            rsp_dbg       <= 1'b0;
        end else if (req_valid) begin
            rsp_cacheable <= sel_attr.cacheable;
            rsp_precise   <= sel_attr.precise;
            rsp_wprot     <= sel_attr.wprot;
            rsp_wviol     <= req_write && sel_attr.wprot;
            rsp_src       <= sel_src;
            rsp_dbg       <= req_dbg;
        end
    end

    // R8: one response for each request, one cycle later.
    p_valid_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R4: at most one region is granted.
    p_single_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    // R6: a disabled region never hits.
    p_disabled_nohit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_en[1] |-> !hit[1]);
    // R5: the unused source code never leaves the block.
    p_src_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_src != 2'b11);
    // R7: a violation implies the protect attribute.
    p_wviol_prot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_wviol) |-> rsp_wprot);
    // R7: a read request never reports a violation.
    p_read_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> !rsp_wviol);
endmodule

// File: tb/tb_mar_attr_resolver.sv
module tb_mar_attr_resolver;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_dbg = 1'b0;
    logic        rsp_valid, rsp_cacheable, rsp_precise, rsp_wprot, rsp_wviol, rsp_dbg;
    logic [1:0]  rsp_src;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // bench copy of the programmed configuration
    logic [7:0] m_base [2];
    logic [7:0] m_mask [2];
    logic       m_en   [2];
    logic [2:0] m_attr [2];
    logic [2:0] m_def;

    always #5 clk = ~clk;

    mar_attr_resolver dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_dbg(req_dbg), .rsp_valid(rsp_valid),
        .rsp_cacheable(rsp_cacheable), .rsp_precise(rsp_precise),
        .rsp_wprot(rsp_wprot), .rsp_wviol(rsp_wviol), .rsp_src(rsp_src),
        .rsp_dbg(rsp_dbg)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [1:0] sel, input logic [7:0] b, input logic [7:0] m,
                             input logic e, input logic [2:0] a);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_sel = sel;
        cfg_wdata = {12'h0, a, e, m, b};
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel < 2'd2) begin
            m_base[sel] = b; m_mask[sel] = m; m_en[sel] = e; m_attr[sel] = a;
        end else if (sel == 2'd2) begin
            m_def = a;
        end
    endtask

    function automatic logic model_hit(input int r, input logic [7:0] top);
        return m_en[r] && (((top ^ m_base[r]) & ~m_mask[r]) == 8'h00);
    endfunction

    // drive at negedge, look at the response one negedge later
    task automatic lookup(input logic [31:0] a, input logic wr, input logic dbg);
        logic [2:0] ea;
        logic [1:0] es;
        string tag;
        if (model_hit(0, a[31:24])) begin
            ea = m_attr[0]; es = 2'b01;
            tag = model_hit(1, a[31:24]) ? "R4" : "R2";
        end else if (model_hit(1, a[31:24])) begin
            ea = m_attr[1]; es = 2'b10; tag = "R3";
        end else begin
            ea = m_def; es = 2'b00; tag = "R5";
        end
        req_valid = 1'b1; req_addr = a; req_write = wr; req_dbg = dbg;
        @(negedge clk);
        req_valid = 1'b0;
        check("R8 valid", 32'(rsp_valid), 32'd1);
        check({tag, " attr"}, 32'({rsp_wprot, rsp_precise, rsp_cacheable}), 32'(ea));
        check({tag, " src"}, 32'(rsp_src), 32'(es));
        check("R7 wviol", 32'(rsp_wviol), 32'(wr & ea[2]));
        check("R9 dbg", 32'(rsp_dbg), 32'(dbg));
    endtask

    task automatic sweep(input int salt);
        for (int i = 0; i < 256; i++) begin
            lookup({i[7:0], 24'(i * 1237 + salt)}, i[0], i[1]);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < 2; r++) begin
            m_base[r] = '0; m_mask[r] = '0; m_en[r] = 1'b0; m_attr[r] = '0;
        end
        m_def = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 valid idle", 32'(rsp_valid), 32'd0);
        req_valid = 1'b1; req_addr = 32'h0000_0000; req_write = 1'b1; req_dbg = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        check("R1 attr", 32'({rsp_wprot, rsp_precise, rsp_cacheable}), 32'd0);
        check("R1 src", 32'(rsp_src), 32'd0);
        // R8: no request, no response
        @(negedge clk);
        check("R8 idle", 32'(rsp_valid), 32'd0);

        // nested regions: R2, R3, R4, R5, R7, R9
        write_cfg(2'd0, 8'h40, 8'h0F, 1'b1, 3'b101);
        write_cfg(2'd1, 8'h40, 8'h3F, 1'b1, 3'b110);
        write_cfg(2'd2, 8'h00, 8'h00, 1'b0, 3'b011);
        sweep(7);

        // R6: disabled all-covering region 0, narrow region 1
        write_cfg(2'd0, 8'h00, 8'hFF, 1'b0, 3'b111);
        write_cfg(2'd1, 8'h80, 8'h00, 1'b1, 3'b100);
        write_cfg(2'd2, 8'h00, 8'h00, 1'b0, 3'b000);
        sweep(99);

        // R4: both regions cover everything
        write_cfg(2'd0, 8'h12, 8'hFF, 1'b1, 3'b010);
        write_cfg(2'd1, 8'h34, 8'hFF, 1'b1, 3'b101);
        sweep(3);

        // R10: select 3 is ignored
        write_cfg(2'd3, 8'h00, 8'h00, 1'b0, 3'b111);
        lookup(32'h5500_0000, 1'b1, 1'b0);

        // R10: same-cycle write sees the old setting, next cycle the new
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = {12'h0, 3'b111, 1'b0, 8'h00, 8'h00};
        req_valid = 1'b1; req_addr = 32'h77FF_FFFF; req_write = 1'b0; req_dbg = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        check("R10 old attr", 32'({rsp_wprot, rsp_precise, rsp_cacheable}), 32'(3'b010));
        check("R10 old src", 32'(rsp_src), 32'd1);
        m_en[0] = 1'b0; m_attr[0] = 3'b111; m_mask[0] = 8'h00; m_base[0] = 8'h00;
        lookup(32'h7700_0000, 1'b1, 1'b0);
        check("R10 new src", 32'(rsp_src), 32'd2);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule